// File: doc/BRIEF.md
# Two-Write Two-Read RAM with In-Word Bank Semaphores

This block is a memory with two write ports and two read ports, built only from simple dual-port RAM banks that each have one write port and one read port. There are four banks, one for every pairing of a write port with a read port. Each write port writes its own two banks, so both read ports can see every write. Each read port reads the two banks assigned to it and must then pick the one that holds the newer value. No separate table records which port wrote an address last. Instead, each bank word keeps one spare bit beside the data as a semaphore. A read port XORs the semaphore bits from its two banks to make its bank choice.

To write a semaphore, a write port must know what the other port's semaphore currently holds at that address. So every write is a read-modify-write. Read port `w` must present the target address two cycles before write port `w` presents the write. For a write that has no useful read of its own, the user issues a dummy read. The sampled semaphore has to pass through registers, and the bank write is pipelined by `WR_LAT` stages, so a write reaches the banks some cycles after it is issued. A shift-register history of recent writes covers that gap. Its entries are compared against the address, and the newest match takes priority over both the semaphores and the bank data. `HIST_DEPTH` must be at least `WR_LAT + 2`.

Top module: `xsr_ram2w2r`

## Requirements
- R1: After synchronous reset every address reads as zero on both read ports, and the read outputs are zero in the first cycle after reset.
- R2: Read data appears exactly one clock after the read address is sampled, with the same latency whether the banks or the bypass history provide it.
- R3: Once a write has drained from the history, a read returns the most recent value written to that address by either write port.
- R4: A read issued inside the update window returns the newest write to that address, taken from the history.
- R5: When both write ports write the same address in the same cycle, write port 1's data is stored and write port 0's write is discarded.
- R6: A read sampled in the same cycle as a write to that address returns the value held before that write.
- R7: Each 72-bit bank word holds the data in bits 68:0 and the semaphore in bit 69, with bits 71:70 held at zero. Write port 0 stores port 1's current semaphore and write port 1 stores the inverse of port 0's, so an XOR of 0 selects port 0's bank and an XOR of 1 selects port 1's bank.
- R8: A write on port `w` uses the semaphore sampled by read port `w` at the same address two cycles earlier, corrected by any newer writes in the history, so mixed back-to-back writes from both ports at the same address keep resolving correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_0 | input | 1 | Write enable, write port 0 |
| wr_addr_0 | input | 4 | Write address, port 0 (must equal read port 0's address two cycles earlier) |
| wr_data_0 | input | 69 | Write data, port 0 |
| wr_en_1 | input | 1 | Write enable, write port 1 |
| wr_addr_1 | input | 4 | Write address, port 1 (must equal read port 1's address two cycles earlier) |
| wr_data_1 | input | 69 | Write data, port 1 |
| rd_addr_0 | input | 4 | Read address, port 0 |
| rd_data_0 | output | 69 | Registered read data, port 0 |
| rd_addr_1 | input | 4 | Read address, port 1 |
| rd_data_1 | output | 69 | Registered read data, port 1 |

## Verification
A single-array reference model predicts every read. The sweeps exercise four patterns. First, quiet full-address sweeps after idle gaps, which force every read through the bank data and the semaphore XOR, so a wrong semaphore encoding shows up as stale data. Second, dense writes from both ports to only two addresses, which keeps every read and every semaphore lookup inside the history window and separates correct newest-entry priority from oldest-entry or bank-only answers. Third, forced same-cycle, same-address writes, which separate port 1 priority from a merge or port 0 priority. Fourth, reads aimed at the address being written in the same cycle, which separate returning the old value from an early forward.

// File: rtl/xsr_pkg.sv
package xsr_pkg;
    localparam int DATA_W  = 69;
    localparam int SPARE_W = 3;
    localparam int WORD_W  = DATA_W + SPARE_W;
    localparam int SEM_POS = DATA_W;
    localparam int ADDR_W  = 4;
    localparam int N_WR    = 2;
    localparam int N_RD    = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  sem;
        data_t data;
    } wr_ent_t;

    function automatic word_t pack_word(data_t d, logic s);
        return {{(SPARE_W-1){1'b0}}, s, d};
    endfunction
endpackage

// File: rtl/xsr_bank.sv
module xsr_bank
    import xsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wword,
    input  addr_t raddr,
    output logic  rd_sem,
    output data_t rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];
    word_t rword_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rword_q <= '0;
        end else begin
            if (we) mem[waddr] <= wword;
            rword_q <= mem[raddr];
        end
    end

    assign rd_sem  = rword_q[SEM_POS];
    assign rd_data = rword_q[DATA_W-1:0];

    // R7: unused spare bits of every word read back stay zero
    p_spare_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rword_q[WORD_W-1:SEM_POS+1] == '0);
endmodule

// File: rtl/xsr_history.sv
module xsr_history
    import xsr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  wr_ent_t [N_WR-1:0]               push,
    output wr_ent_t [DEPTH-1:0][N_WR-1:0]    slots
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else begin
            slots[0] <= push;
            for (int s = 1; s < DEPTH; s++) slots[s] <= slots[s-1];
        end
    end

    // R4: entries age by exactly one slot per cycle
    p_shift_age_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> slots[1] == $past(slots[0]));
endmodule

// File: rtl/xsr_match.sv
module xsr_match
    import xsr_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter bit GET_SEM = 1'b0,
    localparam int OUT_W  = GET_SEM ? 1 : DATA_W
) (
    input  wr_ent_t [DEPTH-1:0][N_WR-1:0] slots,
    input  addr_t                         qaddr,
    input  logic [N_WR-1:0]               lane_mask,
    output logic                          hit,
    output logic [OUT_W-1:0]              value
);
    wr_ent_t ent;

    // oldest first, so the newest matching entry is the one left standing
    always_comb begin
        hit = 1'b0;
        ent = '0;
        for (int s = DEPTH - 1; s >= 0; s--) begin
            for (int l = 0; l < N_WR; l++) begin
                if (lane_mask[l] && slots[s][l].valid && slots[s][l].addr == qaddr) begin
                    hit = 1'b1;
                    ent = slots[s][l];
                end
            end
        end
    end

    if (GET_SEM) begin : g_sem
        assign value = ent.sem;
    end else begin : g_data
        assign value = ent.data;
    end
endmodule

// File: rtl/xsr_ram2w2r.sv
module xsr_ram2w2r
    import xsr_pkg::*;
#(
    parameter int HIST_DEPTH = 8,
    parameter int WR_LAT     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en_0,
    input  logic [ADDR_W-1:0]       wr_addr_0,
    input  logic [DATA_W-1:0]       wr_data_0,
    input  logic                    wr_en_1,
    input  logic [ADDR_W-1:0]       wr_addr_1,
    input  logic [DATA_W-1:0]       wr_data_1,
    input  logic [ADDR_W-1:0]       rd_addr_0,
    output logic [DATA_W-1:0]       rd_data_0,
    input  logic [ADDR_W-1:0]       rd_addr_1,
    output logic [DATA_W-1:0]       rd_data_1
);
    logic  we [N_WR];
    addr_t wa [N_WR];
    data_t wd [N_WR];
    addr_t ra [N_RD];
    data_t rd [N_RD];

    assign we[0] = wr_en_0;  assign wa[0] = wr_addr_0;  assign wd[0] = wr_data_0;
    assign we[1] = wr_en_1;  assign wa[1] = wr_addr_1;  assign wd[1] = wr_data_1;
    assign ra[0] = rd_addr_0;
    assign ra[1] = rd_addr_1;
    assign rd_data_0 = rd[0];
    assign rd_data_1 = rd[1];

    // bank outputs indexed [write port][read port]
    logic    bsem  [N_WR][N_RD];
    data_t   bdata [N_WR][N_RD];
    wr_ent_t [N_WR-1:0] push;
    wr_ent_t pipe_out [N_WR];
    wr_ent_t [HIST_DEPTH-1:0][N_WR-1:0] hist;

    xsr_history #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk(clk), .rst(rst), .push(push), .slots(hist)
    );

    for (genvar w = 0; w < N_WR; w++) begin : g_wr
        localparam int OTHER = 1 - w;
        logic  pre_sem;
        logic  sem_hit;
        logic  sem_hval;
        logic  eff_sem;

        // semaphore of the other port's bank, sampled by read port w
        always_ff @(posedge clk) begin
            if (rst) pre_sem <= 1'b0;
            else     pre_sem <= bsem[OTHER][w];
        end

        xsr_match #(.DEPTH(HIST_DEPTH), .GET_SEM(1'b1)) u_sem_match (
            .slots(hist), .qaddr(wa[w]), .lane_mask(N_WR'(1 << OTHER)),
            .hit(sem_hit), .value(sem_hval)
        );

        assign eff_sem = sem_hit ? sem_hval : pre_sem;

        always_comb begin
            push[w].valid = we[w];
            if (w == 0 && we[1] && wa[1] == wa[0]) push[w].valid = 1'b0;
            push[w].addr = wa[w];
            push[w].data = wd[w];
            push[w].sem  = (w == 0) ? eff_sem : ~eff_sem;
        end

        if (WR_LAT == 0) begin : g_direct
            assign pipe_out[w] = push[w];
        end else begin : g_pipe
            wr_ent_t stg [WR_LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < WR_LAT; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= push[w];
                    for (int i = 1; i < WR_LAT; i++) stg[i] <= stg[i-1];
                end
            end
            assign pipe_out[w] = stg[WR_LAT-1];
        end

        for (genvar r = 0; r < N_RD; r++) begin : g_bank
            xsr_bank u_bank (
                .clk(clk), .rst(rst),
                .we(pipe_out[w].valid), .waddr(pipe_out[w].addr),
                .wword(pack_word(pipe_out[w].data, pipe_out[w].sem)),
                .raddr(ra[r]), .rd_sem(bsem[w][r]), .rd_data(bdata[w][r])
            );
        end
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        logic  hit_c;
        data_t hval_c;
        logic  hit_q;
        data_t hval_q;

        xsr_match #(.DEPTH(HIST_DEPTH), .GET_SEM(1'b0)) u_rd_match (
            .slots(hist), .qaddr(ra[r]), .lane_mask({N_WR{1'b1}}),
            .hit(hit_c), .value(hval_c)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                hit_q  <= 1'b0;
                hval_q <= '0;
            end else begin
                hit_q  <= hit_c;
                hval_q <= hval_c;
            end
        end

        assign rd[r] = hit_q ? hval_q
                     : ((bsem[0][r] ^ bsem[1][r]) ? bdata[1][r] : bdata[0][r]);
    end

    // R1: first cycle out of reset reads zero on both ports
    p_reset_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_0 == '0 && rd_data_1 == '0));

    // R5: colliding writes leave only port 1's entry in the history
    p_collision_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_0 && wr_en_1 && wr_addr_0 == wr_addr_1)
        |=> (!hist[0][0].valid && hist[0][1].valid && hist[0][1].data == $past(wr_data_1)));
endmodule

// File: tb/xsr_ram2w2r_tb_top.sv
`timescale 1ns/1ps
module xsr_ram2w2r_tb_top;
    import xsr_pkg::*;

    localparam int HD = 8;
    localparam int WL = 3;
    localparam int NA = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en_0 = 0, wr_en_1 = 0;
    addr_t wr_addr_0 = '0, wr_addr_1 = '0, rd_addr_0 = '0, rd_addr_1 = '0;
    data_t wr_data_0 = '0, wr_data_1 = '0;
    data_t rd_data_0, rd_data_1;

    always #2 clk = ~clk;

    xsr_ram2w2r #(.HIST_DEPTH(HD), .WR_LAT(WL)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en_0(wr_en_0), .wr_addr_0(wr_addr_0), .wr_data_0(wr_data_0),
        .wr_en_1(wr_en_1), .wr_addr_1(wr_addr_1), .wr_data_1(wr_data_1),
        .rd_addr_0(rd_addr_0), .rd_data_0(rd_data_0),
        .rd_addr_1(rd_addr_1), .rd_data_1(rd_data_1)
    );

    data_t ref_mem [NA];
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;
    bit    exp_ok = 0;
    data_t exp_q [2];
    addr_t exp_a [2];
    addr_t ra_m1 [2];
    addr_t ra_m2 [2];
    int    warm = 0;

    function automatic data_t rnd_data();
        logic [95:0] v = {$urandom, $urandom, $urandom};
        return v[DATA_W-1:0];
    endfunction

    task automatic check(string tag, int port, data_t got, data_t exp, addr_t a);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s port%0d addr %0d: got %h expected %h", tag, port, a, got, exp);
        end
    endtask

    // one cycle: check previous reads, model this cycle, drive pins
    task automatic step(string tag, bit we0, bit we1, addr_t na0, addr_t na1);
        addr_t wa0 = ra_m2[0];
        addr_t wa1 = ra_m2[1];
        data_t d0 = rnd_data();
        data_t d1 = rnd_data();
        if (exp_ok) begin
            check(tag, 0, rd_data_0, exp_q[0], exp_a[0]);
            check(tag, 1, rd_data_1, exp_q[1], exp_a[1]);
        end
        if (warm < 2) begin we0 = 0; we1 = 0; end
        exp_q[0] = ref_mem[na0];  exp_a[0] = na0;
        exp_q[1] = ref_mem[na1];  exp_a[1] = na1;
        if (we0 && !(we1 && wa0 == wa1)) ref_mem[wa0] = d0;
        if (we1) ref_mem[wa1] = d1;
        wr_en_0 = we0; wr_addr_0 = wa0; wr_data_0 = d0;
        wr_en_1 = we1; wr_addr_1 = wa1; wr_data_1 = d1;
        rd_addr_0 = na0; rd_addr_1 = na1;
        ra_m2 = ra_m1;
        ra_m1[0] = na0; ra_m1[1] = na1;
        exp_ok = 1;
        if (warm < 2) warm++;
        @(negedge clk);
    endtask

    // idle long enough to drain the history, then read every address
    task automatic quiet_sweep(string tag);
        for (int i = 0; i < HD + WL + 3; i++) step(tag, 0, 0, '0, '0);
        for (int a = 0; a < NA; a++) step(tag, 0, 0, addr_t'(a), addr_t'(NA - 1 - a));
    endtask

    // mode 0: random reads; 1: reads hit this cycle's write address; 2: forced collision
    task automatic burst(string tag, int n, int amask, int wpct, int mode);
        for (int i = 0; i < n; i++) begin
            bit e0 = ($urandom % 100) < wpct;
            bit e1 = ($urandom % 100) < wpct;
            addr_t a0 = addr_t'($urandom & amask);
            addr_t a1 = addr_t'($urandom & amask);
            if (mode == 1) begin a0 = ra_m2[0]; a1 = ra_m2[1]; end
            if (mode == 2) begin a1 = a0; e0 = 1; e1 = 1; end
            step(tag, e0, e1, a0, a1);
        end
    endtask

    initial begin
        for (int i = 0; i < NA; i++) ref_mem[i] = '0;
        ra_m1[0] = '0; ra_m1[1] = '0; ra_m2[0] = '0; ra_m2[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs zero right after reset, then every address reads zero
        check("R1", 0, rd_data_0, '0, '0);
        check("R1", 1, rd_data_1, '0, '0);
        for (int a = 0; a < NA; a++) step("R1", 0, 0, addr_t'(a), addr_t'(NA - 1 - a));
        // R3/R7: sparse writes, bank path with semaphore selection
        burst("R3", 200, NA - 1, 20, 0);
        quiet_sweep("R3/R7");
        // R4/R8: dense writes on two addresses, history bypass and semaphore chain
        burst("R4", 400, 1, 80, 0);
        quiet_sweep("R7");
        burst("R8", 400, 3, 90, 0);
        quiet_sweep("R8");
        // R5: same-address writes in the same cycle
        burst("R5", 200, 3, 100, 2);
        quiet_sweep("R5");
        // R6: read of the address being written this cycle
        burst("R6", 200, 1, 70, 1);
        quiet_sweep("R6");
        // R2: long random mix, every read compared one cycle later
        burst("R2", 3000, NA - 1, 50, 0);
        quiet_sweep("R2");
        step("R2", 0, 0, '0, '0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule